// File: doc/BRIEF.md
# LSB-First CRC-7 Packet Checker

This block guards a serial command path with a 7-bit cyclic redundancy check. A packet framer upstream presents the command bytes one at a time. It pulses a start marker at the head of each packet and presents the closing check byte on a separate strobe. The block keeps a running remainder over the command bytes. It takes the bits of each byte lowest first, in line order, and uses the generator 0x91 in its reflected form. Each byte is folded into the remainder in a single clock.

When checking is switched on, the low seven bits of the closing byte must equal the remainder. On a match the block issues a one-cycle accept pulse. Otherwise it issues a one-cycle discard pulse and raises a sticky error flag, which stays up until a clear pulse. When checking is off, the closing strobe marks the end of the packet and always yields an accept. The reply path needs no generator.

Top module: `crc7_packet_checker`

## Requirements
- R1: For every data-strobe cycle the remainder becomes: the old remainder XOR the byte, then eight steps, each of which XORs 0x91 in when bit 0 is set and then shifts right by one. Cycles without a data strobe leave the remainder unchanged, so gaps between bytes do not matter.
- R2: The command bytes 0x83 then 0x01 give a remainder of 0x17, so a closing byte of 0x17 is accepted.
- R3: A start pulse alone sets the remainder to zero. A start pulse in the same cycle as a data strobe makes that byte the first byte of a new packet, folded into a zero seed. A packet with no command bytes has remainder 0x00.
- R4: Only bits 6..0 of the closing byte are compared with the remainder. Bit 7 has no effect on the result.
- R5: With the enable input low, every closing strobe gives an accept, whatever the closing byte is, and the error flag is left as it was.
- R6: With the enable input high, a closing byte whose low seven bits differ from the remainder gives a discard pulse and sets the error flag.
- R7: Each closing strobe gives exactly one of accept or discard. That output is high for exactly the one cycle after the strobe. Neither output is ever high at any other time.
- R8: The error flag stays set until a clear pulse. If a clear pulse and a new mismatch fall in the same cycle, the flag stays set.
- R9: After a synchronous active-low reset, accept, discard and the error flag are low and the remainder is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| crc_en | input | 1 | High selects checked mode |
| pkt_start | input | 1 | Start-of-packet pulse, clears the remainder |
| byte_valid | input | 1 | Strobe for a command byte |
| byte_data | input | 8 | Command byte |
| end_valid | input | 1 | Strobe for the closing check byte (end of packet) |
| end_byte | input | 8 | Closing check byte |
| err_clr | input | 1 | Pulse that clears the error flag |
| cmd_accept | output | 1 | One-cycle pulse: the packet may be executed |
| cmd_discard | output | 1 | One-cycle pulse: the packet must be dropped |
| crc_err | output | 1 | Sticky mismatch flag |

## Verification
The bench applies the fixed vector 0x83, 0x01 to catch a design that shifts left or uses the unreflected generator, since such a design would discard a valid packet. It sets bit 7 of a correct closing byte; a design that compares all eight bits would discard that packet. It starts a packet in the same cycle as its first byte and also sends a packet with no command bytes. A design that clears the remainder after the byte, or that fails to clear it, would then carry remainder state from one packet into the next. The bench also sends a clear pulse in the same cycle as a new mismatch, toggles the enable with the flag both set and clear, and sends long random packets with gaps. These catch a lost error, an error flag touched in the unchecked mode, and pulses that are doubled or missing.

// File: rtl/crc7_pkg.sv
// Package: shared constants for the CRC-7 packet checker.
// Assumes byte-wide command data and a generator whose top bit is set.
package crc7_pkg;
    localparam int          BYTE_W   = 8;
    localparam int          REM_W    = 7;
    localparam int          POLY_W   = REM_W + 1;
    localparam logic [7:0]  GEN_POLY = 8'h91;
endpackage

// File: rtl/crc7_byte_step.sv
// crc7_byte_step: purely combinational fold of one data word into the
// running remainder. Bits are consumed lowest first. Each bit step XORs the
// generator in when bit 0 is set and then shifts right by one. The chain is
// unrolled by a generate loop, one stage per data bit.
// Assumes POLY has its top bit (bit REM_W) set.
module crc7_byte_step #(
    parameter int              DATA_W = crc7_pkg::BYTE_W,
    parameter int              REM_W  = crc7_pkg::REM_W,
    parameter logic [REM_W:0]  POLY   = crc7_pkg::GEN_POLY
) (
    input  logic [REM_W-1:0]  rem_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [REM_W-1:0]  rem_out
);
    localparam int POLY_W = REM_W + 1;
    localparam int WORK_W = (DATA_W > POLY_W) ? DATA_W : POLY_W;

    logic [DATA_W:0][WORK_W-1:0] stage;
    logic [WORK_W-1:0]           poly_ext;

    // Seed the chain with remainder XOR data, both zero-extended.
    always_comb begin
        logic [WORK_W-1:0] rem_ext;
        logic [WORK_W-1:0] dat_ext;
        rem_ext                 = '0;
        rem_ext[REM_W-1:0]      = rem_in;
        dat_ext                 = '0;
        dat_ext[DATA_W-1:0]     = data_in;
        poly_ext                = '0;
        poly_ext[POLY_W-1:0]    = POLY;
        stage[0]                = rem_ext ^ dat_ext;
    end

    // One conditional-XOR-and-shift stage per data bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic [WORK_W-1:0] mixed;
        assign mixed        = stage[i][0] ? (stage[i] ^ poly_ext) : stage[i];
        assign stage[i+1]   = mixed >> 1;
    end

    // Remainder is the low REM_W bits of the final stage.
    assign rem_out = stage[DATA_W][REM_W-1:0];
endmodule

// File: rtl/crc7_accum.sv
// crc7_accum: holds the running remainder of the current packet.
// A start pulse restarts it from zero. A data strobe folds one byte in and,
// if it comes with a start pulse, folds into a zero seed. Idle cycles hold.
module crc7_accum #(
    parameter int              DATA_W = crc7_pkg::BYTE_W,
    parameter int              REM_W  = crc7_pkg::REM_W,
    parameter logic [REM_W:0]  POLY   = crc7_pkg::GEN_POLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_start,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    output logic [REM_W-1:0]  rem
);
    logic [REM_W-1:0] rem_q;
    logic [REM_W-1:0] seed;
    logic [REM_W-1:0] rem_next;

    // Seed selection: a start pulse discards the previous packet's state.
    assign seed = pkt_start ? '0 : rem_q;

    crc7_byte_step #(.DATA_W(DATA_W), .REM_W(REM_W), .POLY(POLY)) u_step (
        .rem_in  (seed),
        .data_in (byte_data),
        .rem_out (rem_next)
    );

    // Remainder register: fold on data, clear on a lone start, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          rem_q <= '0;
        else if (byte_valid) rem_q <= rem_next;
        else if (pkt_start)  rem_q <= '0;
    end

    assign rem = rem_q;

    // A lone start pulse leaves a zero remainder.
    assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start && !byte_valid) |=> (rem_q == '0));

    // Without a strobe the remainder is held.
    assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_start && !byte_valid) |=> $stable(rem_q));
endmodule

// File: rtl/crc7_verdict.sv
// crc7_verdict: turns a closing-byte strobe into one accept or discard pulse,
// registered one cycle later, and keeps the sticky mismatch flag.
// Only the low REM_W bits of the closing byte take part in the comparison.
module crc7_verdict #(
    parameter int DATA_W = crc7_pkg::BYTE_W,
    parameter int REM_W  = crc7_pkg::REM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crc_en,
    input  logic              end_valid,
    input  logic [DATA_W-1:0] end_byte,
    input  logic [REM_W-1:0]  rem,
    input  logic              err_clr,
    output logic              cmd_accept,
    output logic              cmd_discard,
    output logic              crc_err
);
    logic match;
    logic bad;

    // Compare the low bits only; the upper bits of the byte are don't-care.
    assign match = (end_byte[REM_W-1:0] == rem);
    assign bad   = end_valid && crc_en && !match;

    // Verdict pulses: registered, at most one cycle wide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_accept  <= 1'b0;
            cmd_discard <= 1'b0;
        end else begin
            cmd_accept  <= end_valid && !bad;
            cmd_discard <= bad;
        end
    end

    // Sticky flag: a new mismatch wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc_err <= 1'b0;
        else if (bad)     crc_err <= 1'b1;
        else if (err_clr) crc_err <= 1'b0;
    end

    assert_one_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_accept && cmd_discard));

    assert_verdict_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        end_valid |=> (cmd_accept || cmd_discard));

    assert_no_stray_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !end_valid |=> !(cmd_accept || cmd_discard));

    assert_bypass_accepts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (end_valid && !crc_en) |=> cmd_accept);

    assert_bypass_keeps_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (end_valid && !crc_en && !err_clr) |=> $stable(crc_err));

    assert_discard_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_discard |-> crc_err);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err && !err_clr) |=> crc_err);
endmodule

// File: rtl/crc7_packet_checker.sv
// crc7_packet_checker: top level. Joins the remainder accumulator to the
// verdict stage. Assumes an upstream framer that supplies the start pulse
// and the closing-byte strobe and never raises a data strobe in the same
// cycle as the closing strobe.
module crc7_packet_checker #(
    parameter int              DATA_W = crc7_pkg::BYTE_W,
    parameter int              REM_W  = crc7_pkg::REM_W,
    parameter logic [REM_W:0]  POLY   = crc7_pkg::GEN_POLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crc_en,
    input  logic              pkt_start,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              end_valid,
    input  logic [DATA_W-1:0] end_byte,
    input  logic              err_clr,
    output logic              cmd_accept,
    output logic              cmd_discard,
    output logic              crc_err
);
    logic [REM_W-1:0] rem;

    crc7_accum #(.DATA_W(DATA_W), .REM_W(REM_W), .POLY(POLY)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_start  (pkt_start),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .rem        (rem)
    );

    crc7_verdict #(.DATA_W(DATA_W), .REM_W(REM_W)) u_verdict (
        .clk         (clk),
        .rst_n       (rst_n),
        .crc_en      (crc_en),
        .end_valid   (end_valid),
        .end_byte    (end_byte),
        .rem         (rem),
        .err_clr     (err_clr),
        .cmd_accept  (cmd_accept),
        .cmd_discard (cmd_discard),
        .crc_err     (crc_err)
    );

    // Reset leaves both pulses and the flag low on the next edge.
    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> !(cmd_accept || cmd_discard || crc_err));
endmodule

// File: tb/crc7_packet_checker_bench.sv
`timescale 1ns/1ps
module crc7_packet_checker_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       crc_en = 1'b0;
    logic       pkt_start = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       end_valid = 1'b0;
    logic [7:0] end_byte = '0;
    logic       err_clr = 1'b0;
    logic       cmd_accept, cmd_discard, crc_err;

    always #5 clk = ~clk;

    crc7_packet_checker u_crc7_packet_checker (
        .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .pkt_start(pkt_start),
        .byte_valid(byte_valid), .byte_data(byte_data), .end_valid(end_valid),
        .end_byte(end_byte), .err_clr(err_clr), .cmd_accept(cmd_accept),
        .cmd_discard(cmd_discard), .crc_err(crc_err)
    );

    int  n_run = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    typedef struct packed { logic acc; logic err; } verdict_t;
    verdict_t exp_q[$];
    string    tag_q[$];

    logic [6:0] m_rem = '0;
    logic       m_err = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Reference fold: the byte rule as stated in R1.
    function automatic logic [6:0] fold(input logic [6:0] r, input logic [7:0] b);
        logic [7:0] v;
        v = {1'b0, r} ^ b;
        for (int k = 0; k < 8; k++) begin
            if (v[0]) v = v ^ 8'h91;
            v = v >> 1;
        end
        return v[6:0];
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit with_start);
        @(negedge clk);
        byte_valid = 1'b1; byte_data = b; pkt_start = with_start;
        m_rem = fold(with_start ? 7'h0 : m_rem, b);
        @(posedge clk); #1;
        byte_valid = 1'b0; pkt_start = 1'b0;
    endtask

    task automatic start_only();
        @(negedge clk);
        pkt_start = 1'b1; m_rem = '0;
        @(posedge clk); #1;
        pkt_start = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clr = 1'b1; m_err = 1'b0;
        @(posedge clk); #1;
        err_clr = 1'b0;
    endtask

    // Driver: closing byte, with the predicted verdict pushed to the scoreboard.
    task automatic end_pkt(input logic [7:0] b, input bit with_clr, input string tag);
        verdict_t e;
        bit bad;
        @(negedge clk);
        end_valid = 1'b1; end_byte = b; err_clr = with_clr;
        bad = crc_en && (b[6:0] != m_rem);
        if (bad) m_err = 1'b1;
        else if (with_clr) m_err = 1'b0;
        e.acc = !bad; e.err = m_err;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(posedge clk); #1;
        end_valid = 1'b0; err_clr = 1'b0;
    endtask

    // Monitor: every pulse must match the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && (cmd_accept || cmd_discard)) begin
            if (cmd_accept && cmd_discard)
                check(1'b0, "R7 both pulses", 3, 1);
            else if (exp_q.size() == 0)
                check(1'b0, "R7 pulse without closing strobe", {cmd_accept, cmd_discard}, 0);
            else begin
                verdict_t e;
                string t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                check(cmd_accept == e.acc, {t, " verdict"}, cmd_accept, e.acc);
                check(cmd_discard == !e.acc, {t, " discard"}, cmd_discard, !e.acc);
                check(crc_err == e.err, {t, " flag"}, crc_err, e.err);
            end
        end
    end

    task automatic check_flag(input string tag);
        @(negedge clk);
        check(crc_err == m_err, tag, crc_err, m_err);
    endtask

    initial begin
        int seed;
        seed = 7;
        repeat (3) @(negedge clk);
        // R9: quiet outputs under reset
        check(!cmd_accept && !cmd_discard && !crc_err, "R9 reset state",
              {cmd_accept, cmd_discard, crc_err}, 0);
        rst_n = 1'b1;
        crc_en = 1'b1;
        idle(2);

        // R2: fixed vector
        start_only(); send_byte(8'h83, 0); send_byte(8'h01, 0);
        check(m_rem == 7'h17, "R2 reference fold", m_rem, 7'h17);
        end_pkt(8'h17, 0, "R2 vector 83 01 -> 17");
        idle(2);

        // R4: bit 7 of the closing byte ignored
        start_only(); send_byte(8'h83, 0); send_byte(8'h01, 0);
        end_pkt(8'h97, 0, "R4 top bit set");
        idle(2);

        // R6: mismatch discards and sets the flag
        start_only(); send_byte(8'h83, 0); send_byte(8'h01, 0);
        end_pkt(8'h16, 0, "R6 mismatch");
        idle(2);

        // R8: flag stays through a good packet, clears on request
        start_only(); send_byte(8'h42, 0);
        end_pkt({1'b0, m_rem}, 0, "R8 sticky through accept");
        idle(2);
        check_flag("R8 still set");
        clear_err();
        check_flag("R8 cleared");

        // R8: clear and new mismatch in the same cycle
        start_only(); send_byte(8'h10, 0);
        end_pkt({1'b1, ~m_rem}, 1, "R8 clear vs mismatch");
        idle(2);
        check_flag("R8 mismatch wins");

        // R5: unchecked mode, flag set then clear
        crc_en = 1'b0;
        start_only(); send_byte(8'h55, 0);
        end_pkt(8'hAA, 0, "R5 bypass flag set");
        clear_err();
        start_only(); send_byte(8'h55, 0);
        end_pkt({1'b0, ~m_rem}, 0, "R5 bypass flag clear");
        idle(2);
        check_flag("R5 flag untouched");
        crc_en = 1'b1;

        // R3: start in the same cycle as the first byte, after stale state
        send_byte(8'hC3, 0); send_byte(8'h3C, 0);
        send_byte(8'h83, 1); send_byte(8'h01, 0);
        end_pkt(8'h17, 0, "R3 start with byte");
        // R3: empty packet
        start_only();
        end_pkt(8'h80, 0, "R3 empty packet");
        // R3: lone start after bytes
        send_byte(8'hFF, 0); start_only(); send_byte(8'h83, 0); send_byte(8'h01, 0);
        end_pkt(8'h17, 0, "R3 lone start");
        idle(2);

        // R1: random packets with gaps, some corrupted
        for (int p = 0; p < 40; p++) begin
            int len;
            logic [7:0] cb;
            len = $urandom(seed + p) % 9;
            start_only();
            for (int k = 0; k < len; k++) begin
                send_byte(8'($urandom), 0);
                if ($urandom % 3 == 0) idle(1 + $urandom % 3);
            end
            cb = {1'($urandom), m_rem};
            if (p % 5 == 4) cb[$urandom % 7] = ~cb[$urandom % 7];
            end_pkt(cb, 0, "R1 random packet");
            if (p % 7 == 6) clear_err();
        end
        idle(4);
        check(exp_q.size() == 0, "R7 missing verdicts", exp_q.size(), 0);
        check_flag("R8 final flag");
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule